// File: doc/BRIEF.md
# Transactional Store Buffer

This block keeps the stores issued inside a hardware transaction away from memory until the transaction finishes. While a transaction is open, each store (a word address, a byte-enable and a data word) is folded into a line entry that covers one 64-byte line. A second store to a line already held merges into the same entry, with later bytes replacing earlier ones. The set of lines held at any moment is the transaction's write-set. Loads issued during the transaction look up the buffer. Bytes that the transaction has written come from the buffer, and all other bytes come from the cache data the requester supplies.

When the transaction commits, the buffer becomes busy and sends every held line to a downstream cache write port, one line per cycle under a valid/ready handshake. The lines go in the order they were first touched, and the last line is flagged. While busy is high, the cache keeps other traffic off that port, so the group lands as one unit, and no new transaction can open. An abort empties the buffer in one step and sends nothing downstream. A store that needs a fresh line while every entry is taken is refused, and the block raises a capacity-abort indication so that the core can abort the transaction.

Top module: `txn_store_buf`

## Requirements
- R1: After reset the block is idle: `tx_active`, `busy`, `wr_valid`, `ld_hit`, `st_accept` and `cap_abort` are all low.
- R2: `tx_begin` in the idle state raises `tx_active` from the next cycle. `tx_begin` has no effect while a transaction is open or while `busy` is high.
- R3: A store is accepted (`st_accept`, combinational) only while `tx_active` is high. Stores presented while idle or busy are dropped, and nothing reaches the write port before a commit.
- R4: A store hits a held line when its tag (`st_addr` above the low three bits) matches that line. It then merges into the existing entry, so no second entry is created for the same line. Only bytes with a set `st_be` bit are replaced, and bit i of `st_be` covers data bits 8i+7..8i. The word index within the line is `st_addr[2:0]`.
- R5: `ld_hit` is high when the line of `ld_addr` is held. `ld_data` byte i comes from the buffer when that byte has been written in the transaction, and from `ld_cache_data` otherwise.
- R6: The buffer holds 8 lines. When all 8 are held, a store to a line that is not held drives `cap_abort` high and `st_accept` low, and the buffer contents do not change. A store to a held line is still accepted.
- R7: `tx_abort` while a transaction is open drops every held line by the next cycle. `tx_active` then falls, and no line write is issued.
- R8: An abort takes priority over a store and over a commit presented in the same cycle. That store is not accepted and no drain starts.
- R9: A commit with lines held raises `busy` on the next cycle. `wr_valid` stays high with a stable payload until `wr_ready`. Exactly one line is transferred per accepted cycle, in first-touch order.
- R10: `wr_last` marks the final line of the group. `busy` falls in the cycle after that line is accepted. A store accepted in the commit cycle is part of the group.
- R11: A commit with no lines held returns to idle on the next cycle without raising `busy` or `wr_valid`.
- R12: For a drained line, `wr_mask` bit k is set exactly for the bytes written in the transaction, and `wr_data` is zero in every byte whose mask bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_begin | input | 1 | Open a transaction |
| tx_commit | input | 1 | Commit the open transaction |
| tx_abort | input | 1 | Abort the open transaction |
| tx_active | output | 1 | A transaction is open |
| busy | output | 1 | Commit drain in progress |
| st_valid | input | 1 | Store request present |
| st_addr | input | 29 | Store word address (tag above, word index in low 3 bits) |
| st_be | input | 8 | Store byte enables |
| st_data | input | 64 | Store data word |
| st_accept | output | 1 | Store taken this cycle |
| cap_abort | output | 1 | Store refused because every entry is taken |
| ld_addr | input | 29 | Load word address |
| ld_cache_data | input | 64 | Word read from the cache for `ld_addr` |
| ld_data | output | 64 | Word merged with buffered bytes |
| ld_hit | output | 1 | The load line is held in the buffer |
| wr_valid | output | 1 | Line write presented downstream |
| wr_ready | input | 1 | Downstream takes the line write |
| wr_tag | output | 26 | Line tag of the write |
| wr_data | output | 512 | Line data |
| wr_mask | output | 64 | Byte mask of written bytes |
| wr_last | output | 1 | Final line of the commit group |

## Verification
The bench goes after merges into a line that is already held. A design that allocated a second entry, or that overwrote bytes whose enable is clear, would show up as an extra line write, a wrong mask, or wrong forwarded load bytes. It fills all eight entries and then offers both a new line and a held line. A faulty capacity check would either accept the ninth line or refuse a legal merge. It presents abort together with a store and a commit, where a wrong priority would drain lines or keep data after the abort. It also holds `wr_ready` low during a drain and issues commits with an empty buffer. A wrong handshake would then drop or repeat lines, change the payload during a stall, or raise `busy` with nothing to send.

// File: rtl/tsb_pkg.sv
// Package: shared types of the transactional store buffer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package tsb_pkg;

    // Life cycle of one transaction as seen by the buffer.
    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_OPEN  = 2'd1,
        TS_DRAIN = 2'd2
    } tsb_state_e;

endpackage

// File: rtl/tsb_pick.sv
// Module: lowest-index picker.
// Returns whether any request bit is set and the index of the lowest one.
// Assumes N >= 1; used for free-entry allocation and drain ordering.
module tsb_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest set bit is the final assignment.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/tsb_match.sv
// Module: tag lookup across all line entries.
// Compares a key against every valid entry tag in parallel.
// Assumes at most one valid entry carries any given tag, so the
// index is formed by OR-ing the indices of matching entries.
module tsb_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 26,
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [TAG_W-1:0]   tags [ENTRIES],
    input  logic [TAG_W-1:0]   key,
    output logic               hit,
    output logic [IW-1:0]      idx
);

    logic [ENTRIES-1:0] eq;

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid[g] && (tags[g] == key);
    end

    // Encode the (single) matching entry.
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eq[i]) begin
                idx = idx | IW'(i);
            end
        end
    end

    assign hit = |eq;

endmodule

// File: rtl/tsb_lines.sv
// Module: line entry storage.
// Each entry holds a valid bit, a line tag, the line bytes and a
// per-byte written mask. A fresh allocation clears data and mask before
// the first bytes land; a merge only touches enabled bytes.
// Assumes the write and release ports are never used in the same cycle
// (writes happen while open, releases while draining).
module tsb_lines #(
    parameter int ENTRIES    = 8,
    parameter int TAG_W      = 26,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 8,
    localparam int IW        = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int WSEL_W    = $clog2(LINE_BYTES / WORD_BYTES),
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int WORD_BITS = WORD_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_all,
    input  logic                  wr_en,
    input  logic                  wr_new,
    input  logic [IW-1:0]         wr_idx,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic [WSEL_W-1:0]     wr_word,
    input  logic [WORD_BYTES-1:0] wr_be,
    input  logic [WORD_BITS-1:0]  wr_data,
    input  logic                  rel_en,
    input  logic [IW-1:0]         rel_idx,
    output logic [ENTRIES-1:0]    valid_o,
    output logic [TAG_W-1:0]      tags_o  [ENTRIES],
    output logic [LINE_BITS-1:0]  lines_o [ENTRIES],
    output logic [LINE_BYTES-1:0] masks_o [ENTRIES]
);

    logic [ENTRIES-1:0]    valid_q;
    logic [TAG_W-1:0]      tag_q  [ENTRIES];
    logic [LINE_BITS-1:0]  line_q [ENTRIES];
    logic [LINE_BYTES-1:0] mask_q [ENTRIES];

    // Valid bits and tags: allocate, release one, or drop all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                tag_q[e] <= '0;
            end
        end else if (clr_all) begin
            valid_q <= '0;
        end else begin
            if (rel_en) begin
                valid_q[rel_idx] <= 1'b0;
            end
            if (wr_en && wr_new) begin
                valid_q[wr_idx] <= 1'b1;
                tag_q[wr_idx]   <= wr_tag;
            end
        end
    end

    // Line bytes and written mask: clear on allocation, then merge bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                line_q[e] <= '0;
                mask_q[e] <= '0;
            end
        end else if (wr_en) begin
            if (wr_new) begin
                line_q[wr_idx] <= '0;
                mask_q[wr_idx] <= '0;
            end
            for (int b = 0; b < WORD_BYTES; b++) begin
                if (wr_be[b]) begin
                    line_q[wr_idx][(int'(wr_word) * WORD_BYTES + b) * 8 +: 8] <= wr_data[b * 8 +: 8];
                    mask_q[wr_idx][int'(wr_word) * WORD_BYTES + b]           <= 1'b1;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign tags_o  = tag_q;
    assign lines_o = line_q;
    assign masks_o = mask_q;

    // Assertion helper: does the write tag already sit in a valid entry?
    logic dup_tag;
    always_comb begin
        dup_tag = 1'b0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (valid_q[e] && (tag_q[e] == wr_tag)) begin
                dup_tag = 1'b1;
            end
        end
    end

    AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_new) |-> !dup_tag); // R4
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (valid_q == '0)); // R7
    AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_new) |-> !valid_q[wr_idx]); // R6

endmodule

// File: rtl/tsb_ctrl.sv
// Module: transaction state machine.
// Tracks idle / open / drain. Abort wins over commit; a commit with
// nothing held (and no store landing in the same cycle) goes straight
// back to idle. Drain ends when the final line is accepted downstream.
// Assumes wr_fire and wr_last come from the drain port of the top.
module tsb_ctrl
    import tsb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_begin,
    input  logic       tx_commit,
    input  logic       tx_abort,
    input  logic       st_take,
    input  logic       any_held,
    input  logic       wr_fire,
    input  logic       wr_last,
    output tsb_state_e state,
    output logic       abort_clr
);

    tsb_state_e state_q, state_d;

    // Next-state selection for the three phases.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_IDLE: begin
                if (tx_begin) state_d = TS_OPEN;
            end
            TS_OPEN: begin
                if (tx_abort) begin
                    state_d = TS_IDLE;
                end else if (tx_commit) begin
                    state_d = (any_held || st_take) ? TS_DRAIN : TS_IDLE;
                end
            end
            TS_DRAIN: begin
                if (wr_fire && wr_last) state_d = TS_IDLE;
            end
            default: state_d = TS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_IDLE;
        else        state_q <= state_d;
    end

    assign state     = state_q;
    assign abort_clr = (state_q == TS_OPEN) && tx_abort;

    AST_ABORT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == TS_OPEN) && tx_abort) |=> (state_q == TS_IDLE)); // R8
    AST_DRAIN_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == TS_DRAIN) |-> $past(tx_commit)); // R9
    AST_BEGIN_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == TS_OPEN) |-> ($past(state_q) == TS_IDLE)); // R2

endmodule

// File: rtl/txn_store_buf.sv
// Module: transactional store buffer (top).
// Buffers stores of an open transaction per cache line, forwards held
// bytes to in-transaction loads, drains all lines as one group on
// commit and drops them all on abort. Loads and stores are single-cycle
// combinational handshakes; the cache is expected to block other writes
// while busy is high.
module txn_store_buf
    import tsb_pkg::*;
#(
    parameter int ENTRIES    = 8,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 8,
    parameter int WADDR_W    = 29,
    localparam int IW        = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int WSEL_W    = $clog2(LINE_BYTES / WORD_BYTES),
    localparam int TAG_W     = WADDR_W - WSEL_W,
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int WORD_BITS = WORD_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_begin,
    input  logic                  tx_commit,
    input  logic                  tx_abort,
    output logic                  tx_active,
    output logic                  busy,
    input  logic                  st_valid,
    input  logic [WADDR_W-1:0]    st_addr,
    input  logic [WORD_BYTES-1:0] st_be,
    input  logic [WORD_BITS-1:0]  st_data,
    output logic                  st_accept,
    output logic                  cap_abort,
    input  logic [WADDR_W-1:0]    ld_addr,
    input  logic [WORD_BITS-1:0]  ld_cache_data,
    output logic [WORD_BITS-1:0]  ld_data,
    output logic                  ld_hit,
    output logic                  wr_valid,
    input  logic                  wr_ready,
    output logic [TAG_W-1:0]      wr_tag,
    output logic [LINE_BITS-1:0]  wr_data,
    output logic [LINE_BYTES-1:0] wr_mask,
    output logic                  wr_last
);

    tsb_state_e            state;
    logic                  abort_clr;
    logic [ENTRIES-1:0]    valid;
    logic [TAG_W-1:0]      tags  [ENTRIES];
    logic [LINE_BITS-1:0]  lines [ENTRIES];
    logic [LINE_BYTES-1:0] masks [ENTRIES];

    logic                  st_hit, free_any, st_try, wr_fire;
    logic [IW-1:0]         st_idx, free_idx, drain_idx, ld_idx;
    logic                  drain_any;

    logic [TAG_W-1:0]      st_tag, ld_tag;
    logic [WSEL_W-1:0]     st_word, ld_word;
    logic [WORD_BITS-1:0]  ld_bword;
    logic [WORD_BYTES-1:0] ld_mword;

    assign st_tag  = st_addr[WADDR_W-1:WSEL_W];
    assign st_word = st_addr[WSEL_W-1:0];
    assign ld_tag  = ld_addr[WADDR_W-1:WSEL_W];
    assign ld_word = ld_addr[WSEL_W-1:0];

    assign tx_active = (state == TS_OPEN);
    assign busy      = (state == TS_DRAIN);

    // Store lookup against held lines.
    tsb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_st_match (
        .valid (valid),
        .tags  (tags),
        .key   (st_tag),
        .hit   (st_hit),
        .idx   (st_idx)
    );

    // Load lookup against held lines.
    tsb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_ld_match (
        .valid (valid),
        .tags  (tags),
        .key   (ld_tag),
        .hit   (ld_hit),
        .idx   (ld_idx)
    );

    // Lowest free entry for a new line; lines are allocated in order.
    tsb_pick #(.N(ENTRIES)) u_free_pick (
        .req (~valid),
        .any (free_any),
        .idx (free_idx)
    );

    // Lowest held entry is next to drain, matching first-touch order.
    tsb_pick #(.N(ENTRIES)) u_drain_pick (
        .req (valid),
        .any (drain_any),
        .idx (drain_idx)
    );

    // Store acceptance: abort in the same cycle suppresses the store.
    assign st_try    = st_valid && tx_active && !tx_abort;
    assign st_accept = st_try && (st_hit || free_any);
    assign cap_abort = st_try && !st_hit && !free_any;

    // Drain port: present the lowest held entry until it is taken.
    assign wr_valid = busy && drain_any;
    assign wr_tag   = tags[drain_idx];
    assign wr_data  = lines[drain_idx];
    assign wr_mask  = masks[drain_idx];
    assign wr_last  = ($countones(valid) == 1);
    assign wr_fire  = wr_valid && wr_ready;

    tsb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_begin  (tx_begin),
        .tx_commit (tx_commit),
        .tx_abort  (tx_abort),
        .st_take   (st_accept),
        .any_held  (drain_any),
        .wr_fire   (wr_fire),
        .wr_last   (wr_last),
        .state     (state),
        .abort_clr (abort_clr)
    );

    tsb_lines #(
        .ENTRIES    (ENTRIES),
        .TAG_W      (TAG_W),
        .LINE_BYTES (LINE_BYTES),
        .WORD_BYTES (WORD_BYTES)
    ) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (abort_clr),
        .wr_en   (st_accept),
        .wr_new  (!st_hit),
        .wr_idx  (st_hit ? st_idx : free_idx),
        .wr_tag  (st_tag),
        .wr_word (st_word),
        .wr_be   (st_be),
        .wr_data (st_data),
        .rel_en  (wr_fire),
        .rel_idx (drain_idx),
        .valid_o (valid),
        .tags_o  (tags),
        .lines_o (lines),
        .masks_o (masks)
    );

    // Load forwarding: pick buffered bytes where written, else cache bytes.
    assign ld_bword = lines[ld_idx][int'(ld_word) * WORD_BITS +: WORD_BITS];
    assign ld_mword = masks[ld_idx][int'(ld_word) * WORD_BYTES +: WORD_BYTES];

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_fwd
        assign ld_data[b * 8 +: 8] = (ld_hit && ld_mword[b]) ? ld_bword[b * 8 +: 8]
                                                             : ld_cache_data[b * 8 +: 8];
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_tag) && $stable(wr_mask) && $stable(wr_data))); // R9
    AST_FULL_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_abort && !tx_commit) |=> $stable(valid)); // R6
    AST_NO_WRITE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> !wr_valid); // R3
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_last) |=> !busy); // R10
    AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && tx_commit && !tx_abort && !drain_any && !st_accept) |=> (!busy && !tx_active)); // R11

endmodule

// File: tb/sim_txn_store_buf.sv
// Bench: behavioural reference (queues of lines in first-touch order)
// compared against the design at every falling edge.
module sim_txn_store_buf;

    localparam int E   = 8;
    localparam int WA  = 29;
    localparam int WS  = 3;
    localparam int TW  = 26;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, tx_begin, tx_commit, tx_abort, tx_active, busy;
    logic st_valid, st_accept, cap_abort;
    logic [WA-1:0]  st_addr, ld_addr;
    logic [7:0]     st_be;
    logic [63:0]    st_data, ld_cache_data, ld_data;
    logic           ld_hit, wr_valid, wr_ready, wr_last;
    logic [TW-1:0]  wr_tag;
    logic [511:0]   wr_data;
    logic [63:0]    wr_mask;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    int            mst;
    logic [TW-1:0] qt[$];
    logic [511:0]  qd[$];
    logic [63:0]   qm[$];
    logic          e_acc;

    function automatic logic [63:0] cache_word(logic [WA-1:0] a);
        return {a ^ 29'h15555555, 6'h2a, a};
    endfunction

    assign ld_cache_data = cache_word(ld_addr);

    txn_store_buf u0 (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
        .tx_abort(tx_abort), .tx_active(tx_active), .busy(busy),
        .st_valid(st_valid), .st_addr(st_addr), .st_be(st_be), .st_data(st_data),
        .st_accept(st_accept), .cap_abort(cap_abort),
        .ld_addr(ld_addr), .ld_cache_data(ld_cache_data), .ld_data(ld_data), .ld_hit(ld_hit),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_tag(wr_tag), .wr_data(wr_data),
        .wr_mask(wr_mask), .wr_last(wr_last)
    );

    task automatic chk(input string rq, input string what, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int find(logic [TW-1:0] t);
        foreach (qt[i]) if (qt[i] == t) return i;
        return -1;
    endfunction

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Compare every output against the reference, mid-cycle.
    task automatic at_neg();
        int sh, lh, w;
        logic e_cap;
        logic [63:0] exp_ld;
        @(negedge clk);
        if (!rst_n) return;
        sh    = find(st_addr[WA-1:WS]);
        e_acc = st_valid && mst == 1 && !tx_abort && (sh >= 0 || qt.size() < E);
        e_cap = st_valid && mst == 1 && !tx_abort && sh < 0 && qt.size() == E;
        chk("R2", "tx_active", tx_active, mst == 1);
        chk("R9", "busy", busy, mst == 2);
        chk("R3", "st_accept", st_accept, e_acc);
        chk("R6", "cap_abort", cap_abort, e_cap);
        lh = find(ld_addr[WA-1:WS]);
        w  = int'(ld_addr[WS-1:0]);
        exp_ld = ld_cache_data;
        if (lh >= 0) begin
            for (int b = 0; b < 8; b++) begin
                if (qm[lh][w * 8 + b]) exp_ld[b * 8 +: 8] = qd[lh][(w * 8 + b) * 8 +: 8];
            end
        end
        chk("R5", "ld_hit", ld_hit, lh >= 0);
        chk("R5", "ld_data", ld_data, exp_ld);
        chk("R3", "wr_valid", wr_valid, mst == 2);
        if (mst == 2) begin
            chk("R9", "wr_tag", wr_tag, qt[0]);
            chk("R12", "wr_data", wr_data, qd[0]);
            chk("R12", "wr_mask", wr_mask, qm[0]);
            chk("R10", "wr_last", wr_last, qt.size() == 1);
        end
    endtask

    // Advance the reference with the inputs held through this cycle.
    task automatic at_pos();
        int h, w;
        logic [511:0] d;
        logic [63:0] m;
        @(posedge clk);
        if (!rst_n) begin
            mst = 0; qt.delete(); qd.delete(); qm.delete();
        end else begin
            case (mst)
                0: if (tx_begin) mst = 1;
                1: begin
                    if (tx_abort) begin
                        qt.delete(); qd.delete(); qm.delete(); mst = 0;
                    end else begin
                        if (e_acc) begin
                            h = find(st_addr[WA-1:WS]);
                            if (h < 0) begin
                                qt.push_back(st_addr[WA-1:WS]); qd.push_back('0); qm.push_back('0);
                                h = qt.size() - 1;
                            end
                            d = qd[h]; m = qm[h]; w = int'(st_addr[WS-1:0]);
                            for (int b = 0; b < 8; b++) begin
                                if (st_be[b]) begin
                                    d[(w * 8 + b) * 8 +: 8] = st_data[b * 8 +: 8];
                                    m[w * 8 + b] = 1'b1;
                                end
                            end
                            qd[h] = d; qm[h] = m;
                        end
                        if (tx_commit) mst = (qt.size() > 0) ? 2 : 0;
                    end
                end
                default: if (wr_ready) begin
                    void'(qt.pop_front()); void'(qd.pop_front()); void'(qm.pop_front());
                    if (qt.size() == 0) mst = 0;
                end
            endcase
        end
        #1;
    endtask

    task automatic cyc();
        at_neg();
        at_pos();
    endtask

    task automatic do_st(int tag, int w, logic [7:0] be, logic [63:0] d);
        st_valid = 1; st_addr = {TW'(tag), WS'(w)}; st_be = be; st_data = d;
        cyc();
        st_valid = 0;
    endtask

    task automatic drain(int ready_mode);
        int g = 0;
        while (mst != 0 && g < 100) begin
            wr_ready = (ready_mode == 0) ? 1'b1 : g[0];
            cyc();
            g++;
        end
        wr_ready = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_up();
    end

    initial begin
        logic [31:0] x;
        rst_n = 0; tx_begin = 0; tx_commit = 0; tx_abort = 0;
        st_valid = 0; st_addr = '0; st_be = '0; st_data = '0;
        ld_addr = '0; wr_ready = 0; mst = 0; e_acc = 0;
        repeat (3) at_pos();
        rst_n = 1;
        at_neg();
        chk("R1", "tx_active", tx_active, 0); chk("R1", "busy", busy, 0);
        chk("R1", "wr_valid", wr_valid, 0); chk("R1", "ld_hit", ld_hit, 0);
        chk("R1", "cap_abort", cap_abort, 0);
        at_pos();

        // Store while idle is dropped; then open and merge into one line.
        do_st(7, 1, 8'hff, 64'h0123_4567_89ab_cdef);
        tx_begin = 1; cyc(); tx_begin = 0;
        do_st(5, 2, 8'hff, 64'h1111_1111_1111_1111);
        do_st(5, 2, 8'h0f, 64'h2222_2222_2222_2222);
        do_st(9, 0, 8'hff, 64'h3333_3333_3333_3333);
        do_st(5, 7, 8'h80, 64'hab00_0000_0000_0000);
        ld_addr = {TW'(5), WS'(2)};
        at_neg();
        chk("R4", "merged load", ld_data, 64'h1111_1111_2222_2222);
        at_pos();
        ld_addr = {TW'(5), WS'(3)}; cyc();
        ld_addr = {TW'(12), WS'(0)}; cyc();

        // Commit; stalls, begin and store during the drain are ignored.
        tx_commit = 1; cyc(); tx_commit = 0;
        tx_begin = 1; st_valid = 1; st_addr = {TW'(9), WS'(1)}; st_be = 8'hff;
        drain(1);
        tx_begin = 0; st_valid = 0;
        at_neg();
        chk("R2", "no open after busy begin", tx_active, 0);
        at_pos();

        // Fill all entries, try a ninth line, merge while full, commit with a store.
        tx_begin = 1; cyc(); tx_begin = 0;
        for (int i = 0; i < 8; i++) do_st(20 + i, i, 8'h01 << i, {8{8'(i + 1)}});
        st_valid = 1; st_addr = {TW'(40), WS'(0)}; st_be = 8'hff;
        at_neg();
        chk("R6", "full refuses new line", {cap_abort, st_accept}, 2'b10);
        at_pos(); st_valid = 0;
        do_st(22, 5, 8'hf0, 64'hdead_beef_0000_0000);
        tx_commit = 1; st_valid = 1; st_addr = {TW'(23), WS'(6)}; st_be = 8'h3c; st_data = 64'h5555_aaaa_5555_aaaa;
        cyc(); tx_commit = 0; st_valid = 0;
        drain(0);

        // Abort with a store and a commit in the same cycle.
        tx_begin = 1; cyc(); tx_begin = 0;
        do_st(30, 0, 8'hff, 64'h7);
        do_st(31, 1, 8'hff, 64'h8);
        tx_abort = 1; tx_commit = 1; st_valid = 1; st_addr = {TW'(32), WS'(0)}; st_be = 8'hff;
        at_neg();
        chk("R8", "abort blocks store", st_accept, 0);
        at_pos();
        tx_abort = 0; tx_commit = 0; st_valid = 0; ld_addr = {TW'(30), WS'(0)};
        at_neg();
        chk("R7", "line dropped", ld_hit, 0); chk("R7", "closed", tx_active, 0);
        chk("R8", "no drain", busy, 0);
        at_pos();

        // Empty commit.
        tx_begin = 1; cyc(); tx_begin = 0;
        tx_commit = 1; cyc(); tx_commit = 0;
        at_neg();
        chk("R11", "no busy", {busy, wr_valid, tx_active}, 3'b000);
        at_pos();

        // Pseudo-random traffic over a small set of lines.
        x = 32'h1234_5678;
        for (int n = 0; n < 3000; n++) begin
            x = x * 32'd1103515245 + 32'd12345;
            tx_begin  = (x[20:18] == 3'd0);
            tx_commit = (mst == 1) && (x[27:24] == 4'd0);
            tx_abort  = (mst == 1) && (x[31:28] == 4'd3) && x[5];
            st_valid  = x[6] | x[7];
            st_addr   = {TW'(x[11:8] % 12), WS'(x[14:12])};
            st_be     = x[23:16] | 8'h01;
            st_data   = {x, ~x};
            ld_addr   = {TW'(x[30:27] % 12), WS'(x[2:0])};
            wr_ready  = x[9] | x[4];
            cyc();
        end
        tx_begin = 0; tx_commit = 0; tx_abort = 0; st_valid = 0;
        drain(0);
        finish_up();
    end

endmodule